// File: doc/BRIEF.md
# Exception Prioritizer and Vector Generator

This block sits beside the control path of a small 32-bit processor pipeline. Every cycle it gathers the exception requests raised by the reset lines, the debug logic, the non-maskable interrupt pin, the interrupt lines and the fetch, execute and memory stages. It picks the single most urgent request and reports it one clock later as a take strobe, a cause code, a debug-class flag and a 32-bit handler address.

Two requests carry state of their own. The non-maskable interrupt is edge-triggered and is held until it is taken. A deferred watch hit is held while the core runs in kernel or debug mode, and it becomes eligible once the core leaves those modes. The handler address depends on the class of the winner. Reset-class requests use a fixed boot address. Debug-class requests use one of two probe-selected addresses. All other exceptions use a selectable base plus a fixed offset.

All pins are plain control and status signals. There is no streaming data path, so the block has no valid/ready handshake.

Top module: `exc_arbiter`

## Requirements
- R1: When several requests are eligible in the same cycle, the winner is the earliest in this order: cold reset, soft reset, debug single step, debug interrupt, NMI, machine check, interrupt, deferred watch, debug instruction break, fetch watch, fetch address error, fetch TLB fault, instruction bus error, debug breakpoint instruction, syscall, break, coprocessor unusable, reserved instruction, overflow, trap, debug data break, data watch, load address error, store address error, load TLB fault, store TLB fault.
- R2: General exceptions report these cause codes: interrupt 0, load/fetch TLB fault 2, store TLB fault 3, fetch or load address error 4, store address error 5, instruction bus error 6, syscall 8, break 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, any watch 23, machine check 24. exc_debug is 0 for all of them.
- R3: Cold reset, soft reset and NMI report code 31, exc_debug 0 and address 0xBFC0_0000.
- R4: NMI is recognised only on a 0-to-1 change of nmi_in. The event is held until it is taken, so exc_take rises two clocks after the rising input. An input that stays high does not trigger again.
- R5: The debug-class requests are single step, debug interrupt, instruction break, breakpoint instruction and data break. They report code 30 and exc_debug 1. The address is 0xBFC0_0480 when probe_trap is 0 and 0xFF20_0200 when probe_trap is 1.
- R6: The debug interrupt request is raised by dbg_int_pin or by dbg_brk_bit.
- R7: The interrupt request is raised when a line is high and its mask bit is 1. Line bits [1:0] come from sw_irq and bits [7:2] from hw_irq, and irq_mask uses the same bit positions.
- R8: General exceptions use address 0x8000_0180 when boot_sel is 0 and 0xBFC0_0380 when boot_sel is 1, that is base 0x8000_0000 or 0xBFC0_0200 plus offset 0x180.
- R9: A pulse on dwatch_req makes a deferred watch pending. The pending watch is not taken while kd_mode is 1. Once kd_mode is 0 it is taken as code 23.
- R10: While dbg_mode is 1, every request that is neither debug-class nor cold or soft reset is ignored. A held NMI event is taken after dbg_mode returns to 0.
- R11: The outputs are registered. Inputs sampled at one clock edge appear after that edge. With nothing eligible, exc_take, exc_code, exc_debug and exc_vec are all 0, and they are also 0 after reset.
- R12: The held NMI event and the pending deferred watch are cleared when they are taken, so each gives an exc_take pulse of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cold_rst | input | 1 | Cold reset request |
| soft_rst | input | 1 | Soft reset request |
| dbg_step | input | 1 | Debug single-step request |
| dbg_int_pin | input | 1 | External debug interrupt pin |
| dbg_brk_bit | input | 1 | Software-set debug break bit |
| nmi_in | input | 1 | Non-maskable interrupt pin (edge-sensitive) |
| mchk | input | 1 | Machine check request |
| hw_irq | input | 6 | Hardware interrupt lines |
| sw_irq | input | 2 | Software interrupt lines |
| irq_mask | input | 8 | Interrupt enables, bit i enables line i |
| dwatch_req | input | 1 | Deferred watch hit pulse |
| f_dib | input | 1 | Debug instruction break (fetch) |
| f_watch | input | 1 | Fetch watch match |
| f_adel | input | 1 | Fetch address error |
| f_tlb | input | 1 | Fetch TLB refill or invalid |
| f_ibe | input | 1 | Instruction bus error |
| x_sdbbp | input | 1 | Debug breakpoint instruction |
| x_sys | input | 1 | Syscall |
| x_brk | input | 1 | Break |
| x_cpu | input | 1 | Coprocessor unusable |
| x_ri | input | 1 | Reserved instruction |
| x_ov | input | 1 | Arithmetic overflow |
| x_tr | input | 1 | Trap taken |
| m_ddb | input | 1 | Debug data break |
| m_watch | input | 1 | Data watch match |
| m_adel | input | 1 | Load address error |
| m_ades | input | 1 | Store address error |
| m_tlbl | input | 1 | Load TLB refill or invalid |
| m_tlbs | input | 1 | Store TLB refill or invalid |
| kd_mode | input | 1 | Core in kernel or debug mode |
| dbg_mode | input | 1 | Core in debug mode |
| probe_trap | input | 1 | Debug vector select |
| boot_sel | input | 1 | General exception base select |
| exc_take | output | 1 | Exception accepted this cycle |
| exc_code | output | 5 | Cause code of the accepted exception |
| exc_debug | output | 1 | Accepted exception is debug-class |
| exc_vec | output | 32 | Handler address |

## Verification
The bench raises every level-driven source alone under all four probe_trap and boot_sel settings. It then raises every pair of level sources. A priority chain built in the wrong order, or a source wired to the wrong slot, would report the lower-ranked code or address. The bench sweeps all 256 mask patterns against each of the eight interrupt lines, which catches a mask that is inverted or shifted by one line. It holds nmi_in high across several cycles and also hides an NMI behind a debug request and behind dbg_mode. A level-sensitive or unlatched NMI would then fire repeatedly, or be lost. The deferred watch is held in kernel mode and released afterwards, so a design that drops it, takes it early or never clears it would show up as a missing or stretched take pulse.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

  localparam int NUM_SRC = 26;
  localparam int SRC_IW  = $clog2(NUM_SRC);
  localparam int CODE_W  = 5;

  // Source slots; the index is the priority rank (0 highest).
  localparam int SRC_COLD   = 0;
  localparam int SRC_SOFT   = 1;
  localparam int SRC_DSS    = 2;
  localparam int SRC_DINT   = 3;
  localparam int SRC_NMI    = 4;
  localparam int SRC_MCHK   = 5;
  localparam int SRC_INT    = 6;
  localparam int SRC_DWATCH = 7;
  localparam int SRC_DIB    = 8;
  localparam int SRC_FWATCH = 9;
  localparam int SRC_FADEL  = 10;
  localparam int SRC_FTLB   = 11;
  localparam int SRC_IBE    = 12;
  localparam int SRC_DBP    = 13;
  localparam int SRC_SYS    = 14;
  localparam int SRC_BP     = 15;
  localparam int SRC_CPU    = 16;
  localparam int SRC_RI     = 17;
  localparam int SRC_OV     = 18;
  localparam int SRC_TR     = 19;
  localparam int SRC_DDB    = 20;
  localparam int SRC_MWATCH = 21;
  localparam int SRC_MADEL  = 22;
  localparam int SRC_MADES  = 23;
  localparam int SRC_MTLBL  = 24;
  localparam int SRC_MTLBS  = 25;

  localparam logic [CODE_W-1:0] CODE_INT   = 5'd0;
  localparam logic [CODE_W-1:0] CODE_TLBL  = 5'd2;
  localparam logic [CODE_W-1:0] CODE_TLBS  = 5'd3;
  localparam logic [CODE_W-1:0] CODE_ADEL  = 5'd4;
  localparam logic [CODE_W-1:0] CODE_ADES  = 5'd5;
  localparam logic [CODE_W-1:0] CODE_IBE   = 5'd6;
  localparam logic [CODE_W-1:0] CODE_SYS   = 5'd8;
  localparam logic [CODE_W-1:0] CODE_BP    = 5'd9;
  localparam logic [CODE_W-1:0] CODE_RI    = 5'd10;
  localparam logic [CODE_W-1:0] CODE_CPU   = 5'd11;
  localparam logic [CODE_W-1:0] CODE_OV    = 5'd12;
  localparam logic [CODE_W-1:0] CODE_TR    = 5'd13;
  localparam logic [CODE_W-1:0] CODE_WATCH = 5'd23;
  localparam logic [CODE_W-1:0] CODE_MCHK  = 5'd24;
  localparam logic [CODE_W-1:0] CODE_DEBUG = 5'd30;
  localparam logic [CODE_W-1:0] CODE_BOOT  = 5'd31;

  typedef enum logic [1:0] {
    CLS_BOOT  = 2'd0,
    CLS_DEBUG = 2'd1,
    CLS_GEN   = 2'd2
  } exc_class_e;

  function automatic exc_class_e src_class(input int idx);
    case (idx)
      SRC_COLD, SRC_SOFT, SRC_NMI:                   return CLS_BOOT;
      SRC_DSS, SRC_DINT, SRC_DIB, SRC_DBP, SRC_DDB:  return CLS_DEBUG;
      default:                                       return CLS_GEN;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] src_code(input int idx);
    case (idx)
      SRC_INT:                            return CODE_INT;
      SRC_MCHK:                           return CODE_MCHK;
      SRC_DWATCH, SRC_FWATCH, SRC_MWATCH: return CODE_WATCH;
      SRC_FADEL, SRC_MADEL:               return CODE_ADEL;
      SRC_MADES:                          return CODE_ADES;
      SRC_FTLB, SRC_MTLBL:                return CODE_TLBL;
      SRC_MTLBS:                          return CODE_TLBS;
      SRC_IBE:                            return CODE_IBE;
      SRC_SYS:                            return CODE_SYS;
      SRC_BP:                             return CODE_BP;
      SRC_CPU:                            return CODE_CPU;
      SRC_RI:                             return CODE_RI;
      SRC_OV:                             return CODE_OV;
      SRC_TR:                             return CODE_TR;
      default: begin
        if (src_class(idx) == CLS_DEBUG) return CODE_DEBUG;
        return CODE_BOOT;
      end
    endcase
  endfunction

  // Sources that stay live while the core is in debug mode.
  function automatic logic [NUM_SRC-1:0] dbg_keep_mask();
    logic [NUM_SRC-1:0] m;
    for (int i = 0; i < NUM_SRC; i++) begin
      m[i] = (src_class(i) == CLS_DEBUG) || (i == SRC_COLD) || (i == SRC_SOFT);
    end
    return m;
  endfunction

endpackage

// File: rtl/exc_pending_regs.sv
module exc_pending_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic dwatch_req,
  input  logic kd_mode,
  input  logic take_nmi,
  input  logic take_dwatch,
  output logic nmi_pend,
  output logic dwatch_ready
);

  logic nmi_prev;
  logic nmi_rise;
  logic dw_pend;

  assign nmi_rise = nmi_in & ~nmi_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi_in;
      if (nmi_rise)      nmi_pend <= 1'b1;
      else if (take_nmi) nmi_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dw_pend <= 1'b0;
    end else begin
      if (dwatch_req)       dw_pend <= 1'b1;
      else if (take_dwatch) dw_pend <= 1'b0;
    end
  end

  assign dwatch_ready = dw_pend & ~kd_mode;

  // R4: a level that was already high cannot create a new NMI event
  assert_nmi_no_retrigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_pend && nmi_prev) |=> !nmi_pend);

  // R12: taking the NMI clears the event unless a fresh edge arrives
  assert_nmi_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi && nmi_prev) |=> !nmi_pend);

  // R9: a pending watch survives kernel/debug mode
  assert_dwatch_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_pend && kd_mode) |=> dw_pend);

  // R9: the watch is never offered while in kernel/debug mode
  assert_dwatch_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kd_mode |-> !take_dwatch);

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N    = 26,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic          any,
  output logic [IW-1:0] idx
);

  logic [N-1:0] above;

  assign above[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign above[i] = above[i-1] | req[i-1];
  end

  assign grant = req & ~above;
  assign any   = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (grant[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
  import exc_arb_pkg::*;
#(
  parameter logic [31:0] VEC_BOOT   = 32'hBFC0_0000,
  parameter logic [31:0] VEC_DBG_LO = 32'hBFC0_0480,
  parameter logic [31:0] VEC_DBG_HI = 32'hFF20_0200,
  parameter logic [31:0] BASE_LO    = 32'h8000_0000,
  parameter logic [31:0] BASE_HI    = 32'hBFC0_0200,
  parameter logic [31:0] GEN_OFS    = 32'h0000_0180
) (
  input  logic [SRC_IW-1:0] sel_idx,
  input  logic              probe_trap,
  input  logic              boot_sel,
  output logic [CODE_W-1:0] code,
  output logic              is_dbg,
  output logic [31:0]       vec
);

  exc_class_e cls;

  always_comb begin
    cls    = src_class(int'(sel_idx));
    code   = src_code(int'(sel_idx));
    is_dbg = (cls == CLS_DEBUG);
    case (cls)
      CLS_BOOT:  vec = VEC_BOOT;
      CLS_DEBUG: vec = probe_trap ? VEC_DBG_HI : VEC_DBG_LO;
      default:   vec = (boot_sel ? BASE_HI : BASE_LO) + GEN_OFS;
    endcase
  end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_arb_pkg::*;
#(
  parameter int          N_HW_IRQ   = 6,
  parameter int          N_SW_IRQ   = 2,
  parameter logic [31:0] VEC_BOOT   = 32'hBFC0_0000,
  parameter logic [31:0] VEC_DBG_LO = 32'hBFC0_0480,
  parameter logic [31:0] VEC_DBG_HI = 32'hFF20_0200,
  parameter logic [31:0] BASE_LO    = 32'h8000_0000,
  parameter logic [31:0] BASE_HI    = 32'hBFC0_0200,
  parameter logic [31:0] GEN_OFS    = 32'h0000_0180,
  localparam int         N_IRQ      = N_HW_IRQ + N_SW_IRQ
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cold_rst,
  input  logic                soft_rst,
  input  logic                dbg_step,
  input  logic                dbg_int_pin,
  input  logic                dbg_brk_bit,
  input  logic                nmi_in,
  input  logic                mchk,
  input  logic [N_HW_IRQ-1:0] hw_irq,
  input  logic [N_SW_IRQ-1:0] sw_irq,
  input  logic [N_IRQ-1:0]    irq_mask,
  input  logic                dwatch_req,
  input  logic                f_dib,
  input  logic                f_watch,
  input  logic                f_adel,
  input  logic                f_tlb,
  input  logic                f_ibe,
  input  logic                x_sdbbp,
  input  logic                x_sys,
  input  logic                x_brk,
  input  logic                x_cpu,
  input  logic                x_ri,
  input  logic                x_ov,
  input  logic                x_tr,
  input  logic                m_ddb,
  input  logic                m_watch,
  input  logic                m_adel,
  input  logic                m_ades,
  input  logic                m_tlbl,
  input  logic                m_tlbs,
  input  logic                kd_mode,
  input  logic                dbg_mode,
  input  logic                probe_trap,
  input  logic                boot_sel,
  output logic                exc_take,
  output logic [CODE_W-1:0]   exc_code,
  output logic                exc_debug,
  output logic [31:0]         exc_vec
);

  localparam logic [NUM_SRC-1:0] KEEP_IN_DBG = dbg_keep_mask();

  logic [N_IRQ-1:0]   irq_lines;
  logic               nmi_pend;
  logic               dwatch_ready;
  logic [NUM_SRC-1:0] req_raw;
  logic [NUM_SRC-1:0] req_eff;
  logic [NUM_SRC-1:0] grant;
  logic               any_req;
  logic [SRC_IW-1:0]  win_idx;
  logic [CODE_W-1:0]  nxt_code;
  logic               nxt_dbg;
  logic [31:0]        nxt_vec;

  assign irq_lines = {hw_irq, sw_irq};

  always_comb begin
    req_raw             = '0;
    req_raw[SRC_COLD]   = cold_rst;
    req_raw[SRC_SOFT]   = soft_rst;
    req_raw[SRC_DSS]    = dbg_step;
    req_raw[SRC_DINT]   = dbg_int_pin | dbg_brk_bit;
    req_raw[SRC_NMI]    = nmi_pend;
    req_raw[SRC_MCHK]   = mchk;
    req_raw[SRC_INT]    = |(irq_lines & irq_mask);
    req_raw[SRC_DWATCH] = dwatch_ready;
    req_raw[SRC_DIB]    = f_dib;
    req_raw[SRC_FWATCH] = f_watch;
    req_raw[SRC_FADEL]  = f_adel;
    req_raw[SRC_FTLB]   = f_tlb;
    req_raw[SRC_IBE]    = f_ibe;
    req_raw[SRC_DBP]    = x_sdbbp;
    req_raw[SRC_SYS]    = x_sys;
    req_raw[SRC_BP]     = x_brk;
    req_raw[SRC_CPU]    = x_cpu;
    req_raw[SRC_RI]     = x_ri;
    req_raw[SRC_OV]     = x_ov;
    req_raw[SRC_TR]     = x_tr;
    req_raw[SRC_DDB]    = m_ddb;
    req_raw[SRC_MWATCH] = m_watch;
    req_raw[SRC_MADEL]  = m_adel;
    req_raw[SRC_MADES]  = m_ades;
    req_raw[SRC_MTLBL]  = m_tlbl;
    req_raw[SRC_MTLBS]  = m_tlbs;
  end

  assign req_eff = dbg_mode ? (req_raw & KEEP_IN_DBG) : req_raw;

  exc_pending_regs u_pend (
    .clk          (clk),
    .rst_n        (rst_n),
    .nmi_in       (nmi_in),
    .dwatch_req   (dwatch_req),
    .kd_mode      (kd_mode),
    .take_nmi     (grant[SRC_NMI]),
    .take_dwatch  (grant[SRC_DWATCH]),
    .nmi_pend     (nmi_pend),
    .dwatch_ready (dwatch_ready)
  );

  exc_prio_pick #(.N(NUM_SRC)) u_pick (
    .req   (req_eff),
    .grant (grant),
    .any   (any_req),
    .idx   (win_idx)
  );

  exc_vec_gen #(
    .VEC_BOOT   (VEC_BOOT),
    .VEC_DBG_LO (VEC_DBG_LO),
    .VEC_DBG_HI (VEC_DBG_HI),
    .BASE_LO    (BASE_LO),
    .BASE_HI    (BASE_HI),
    .GEN_OFS    (GEN_OFS)
  ) u_vec (
    .sel_idx    (win_idx),
    .probe_trap (probe_trap),
    .boot_sel   (boot_sel),
    .code       (nxt_code),
    .is_dbg     (nxt_dbg),
    .vec        (nxt_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_take  <= 1'b0;
      exc_code  <= '0;
      exc_debug <= 1'b0;
      exc_vec   <= '0;
    end else begin
      exc_take  <= any_req;
      exc_code  <= any_req ? nxt_code : '0;
      exc_debug <= any_req & nxt_dbg;
      exc_vec   <= any_req ? nxt_vec : '0;
    end
  end

  // R1: the picker never grants more than one source
  assert_single_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3: cold reset always wins and lands on the boot address
  assert_cold_boot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cold_rst |=> (exc_take && exc_code == CODE_BOOT && exc_vec == VEC_BOOT));

  // R10: in debug mode only debug or reset-class results appear
  assert_dbg_mode_filter_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && !nmi_pend) |=> (!exc_take || exc_debug || exc_code == CODE_BOOT));

  // R5: debug-class results use the probe-selected address
  assert_dbg_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && exc_debug) |-> (exc_vec == ($past(probe_trap) ? VEC_DBG_HI : VEC_DBG_LO)));

  // R7: an interrupt result needs an enabled line in the previous cycle
  assert_irq_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !exc_debug && exc_code == CODE_INT) |-> $past(|(irq_lines & irq_mask)));

  // R11: outputs stay at zero when no exception is taken
  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |-> (exc_code == '0 && exc_vec == '0 && !exc_debug));

endmodule

// File: tb/exc_arbiter_bench.sv
`timescale 1ns/1ps
module exc_arbiter_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [25:0] req = '0;
  logic        brk_bit = 1'b0;
  logic        nmi_v = 1'b0;
  logic        dw_v = 1'b0;
  logic [5:0]  hw_v = '0;
  logic [1:0]  sw_v = '0;
  logic [7:0]  mask_v = 8'hFF;
  logic        kd_v = 1'b0;
  logic        dbgm_v = 1'b0;
  logic        probe_v = 1'b0;
  logic        boot_v = 1'b0;

  logic        exc_take;
  logic [4:0]  exc_code;
  logic        exc_debug;
  logic [31:0] exc_vec;

  int checks = 0;
  int fails = 0;

  exc_arbiter u_exc_arbiter (
    .clk(clk), .rst_n(rst_n),
    .cold_rst(req[0]), .soft_rst(req[1]), .dbg_step(req[2]),
    .dbg_int_pin(req[3]), .dbg_brk_bit(brk_bit), .nmi_in(nmi_v),
    .mchk(req[5]), .hw_irq(hw_v | {5'b0, req[6]}), .sw_irq(sw_v),
    .irq_mask(mask_v), .dwatch_req(dw_v),
    .f_dib(req[8]), .f_watch(req[9]), .f_adel(req[10]), .f_tlb(req[11]),
    .f_ibe(req[12]), .x_sdbbp(req[13]), .x_sys(req[14]), .x_brk(req[15]),
    .x_cpu(req[16]), .x_ri(req[17]), .x_ov(req[18]), .x_tr(req[19]),
    .m_ddb(req[20]), .m_watch(req[21]), .m_adel(req[22]), .m_ades(req[23]),
    .m_tlbl(req[24]), .m_tlbs(req[25]),
    .kd_mode(kd_v), .dbg_mode(dbgm_v), .probe_trap(probe_v), .boot_sel(boot_v),
    .exc_take(exc_take), .exc_code(exc_code), .exc_debug(exc_debug), .exc_vec(exc_vec)
  );

  // Expected values from the requirements (slot = priority rank)
  function automatic bit exp_is_dbg(input int s);
    return (s == 2 || s == 3 || s == 8 || s == 13 || s == 20);
  endfunction

  function automatic bit exp_is_boot(input int s);
    return (s == 0 || s == 1 || s == 4);
  endfunction

  function automatic logic [4:0] exp_code(input int s);
    if (exp_is_boot(s)) return 5'd31;
    if (exp_is_dbg(s))  return 5'd30;
    case (s)
      6: return 5'd0;
      5: return 5'd24;
      7, 9, 21: return 5'd23;
      10, 22: return 5'd4;
      23: return 5'd5;
      11, 24: return 5'd2;
      25: return 5'd3;
      12: return 5'd6;
      14: return 5'd8;
      15: return 5'd9;
      16: return 5'd11;
      17: return 5'd10;
      18: return 5'd12;
      default: return 5'd13;
    endcase
  endfunction

  function automatic logic [31:0] exp_vec(input int s, input bit p, input bit b);
    if (exp_is_boot(s)) return 32'hBFC0_0000;
    if (exp_is_dbg(s))  return p ? 32'hFF20_0200 : 32'hBFC0_0480;
    return (b ? 32'hBFC0_0200 : 32'h8000_0000) + 32'h180;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_take(input string tag, input int s, input bit p, input bit b);
    chk({tag, " take"}, {31'b0, exc_take}, 32'd1);
    chk({tag, " code"}, {27'b0, exc_code}, {27'b0, exp_code(s)});
    chk({tag, " debug"}, {31'b0, exc_debug}, {31'b0, exp_is_dbg(s)});
    chk({tag, " vec"}, exc_vec, exp_vec(s, p, b));
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " idle take"}, {31'b0, exc_take}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset take", {31'b0, exc_take}, 32'd0);
    chk("R11 reset vec", exc_vec, 32'd0);
    chk("R11 reset code", {27'b0, exc_code}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R11 after reset");

    // R2 R3 R5 R8 R11: each level source alone, all selector settings
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < 2; b++) begin
        for (int s = 0; s < 26; s++) begin
          if (s == 4 || s == 7) continue;
          probe_v = p[0]; boot_v = b[0];
          req = '0; req[s] = 1'b1;
          @(negedge clk);
          chk_take($sformatf("R2/R3/R5/R8 single slot %0d", s), s, p[0], b[0]);
          req = '0;
          @(negedge clk);
          chk_idle("R11 release");
        end
      end
    end
    probe_v = 0; boot_v = 0;

    // R1: every pair of level sources
    for (int i = 0; i < 26; i++) begin
      for (int j = i + 1; j < 26; j++) begin
        if (i == 4 || i == 7 || j == 4 || j == 7) continue;
        req = '0; req[i] = 1'b1; req[j] = 1'b1;
        @(negedge clk);
        chk_take($sformatf("R1 pair %0d/%0d", i, j), i, 1'b0, 1'b0);
        req = '0;
        @(negedge clk);
      end
    end

    // R6: debug interrupt via the software break bit
    brk_bit = 1'b1;
    @(negedge clk);
    chk_take("R6 break bit", 3, 1'b0, 1'b0);
    brk_bit = 1'b0;
    @(negedge clk);

    // R7: every line against every mask pattern
    for (int l = 0; l < 8; l++) begin
      for (int m = 0; m < 256; m++) begin
        mask_v = m[7:0];
        hw_v = '0; sw_v = '0;
        if (l < 2) sw_v[l] = 1'b1; else hw_v[l-2] = 1'b1;
        @(negedge clk);
        chk($sformatf("R7 line %0d mask %0h", l, m), {31'b0, exc_take}, {31'b0, m[l]});
        if (m[l]) chk("R7 code", {27'b0, exc_code}, 32'd0);
      end
    end
    hw_v = '0; sw_v = '0; mask_v = 8'hFF;
    @(negedge clk);

    // R4 R12: NMI edge, held level, second edge
    nmi_v = 1'b1;
    @(negedge clk);
    chk_idle("R4 nmi latency");
    @(negedge clk);
    chk_take("R4 nmi taken", 4, 1'b0, 1'b0);
    repeat (3) begin
      @(negedge clk);
      chk_idle("R12 nmi held high");
    end
    nmi_v = 1'b0;
    @(negedge clk);
    nmi_v = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_take("R4 nmi second edge", 4, 1'b0, 1'b0);
    nmi_v = 1'b0;
    @(negedge clk);
    chk_idle("R12 nmi one pulse");

    // R1 R4: NMI held behind single step
    nmi_v = 1'b1; req[2] = 1'b1;
    @(negedge clk);
    chk_take("R1 step over nmi", 2, 1'b0, 1'b0);
    @(negedge clk);
    chk_take("R1 step over nmi again", 2, 1'b0, 1'b0);
    req[2] = 1'b0;
    @(negedge clk);
    chk_take("R4 nmi after step", 4, 1'b0, 1'b0);
    @(negedge clk);
    chk_idle("R12 nmi cleared");
    nmi_v = 1'b0;
    @(negedge clk);

    // R9 R12: deferred watch held in kernel mode
    kd_v = 1'b1; dw_v = 1'b1;
    @(negedge clk);
    dw_v = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk_idle("R9 watch held in kernel");
    end
    kd_v = 1'b0;
    @(negedge clk);
    chk_take("R9 watch after kernel exit", 7, 1'b0, 1'b0);
    @(negedge clk);
    chk_idle("R12 watch one pulse");

    // R1 R9: deferred watch ranks above syscall, below interrupt
    dw_v = 1'b1; req[14] = 1'b1;
    @(negedge clk);
    dw_v = 1'b0;
    chk_take("R1 syscall before watch pending", 14, 1'b0, 1'b0);
    @(negedge clk);
    chk_take("R1 watch over syscall", 7, 1'b0, 1'b0);
    req[14] = 1'b0;
    @(negedge clk);
    chk_idle("R12 watch cleared");

    // R10: debug mode filter
    dbgm_v = 1'b1; kd_v = 1'b1;
    req[14] = 1'b1; req[5] = 1'b1; req[6] = 1'b1;
    @(negedge clk);
    chk_idle("R10 general ignored");
    req[2] = 1'b1;
    @(negedge clk);
    chk_take("R10 debug allowed", 2, 1'b0, 1'b0);
    req[2] = 1'b0; req[1] = 1'b1;
    @(negedge clk);
    chk_take("R10 soft reset allowed", 1, 1'b0, 1'b0);
    req = '0;
    nmi_v = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_idle("R10 nmi held in debug mode");
    @(negedge clk);
    chk_idle("R10 nmi still held");
    dbgm_v = 1'b0; kd_v = 1'b0;
    @(negedge clk);
    chk_take("R10 nmi after debug mode", 4, 1'b0, 1'b0);
    nmi_v = 1'b0;
    @(negedge clk);
    chk_idle("R12 final idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule